// File: doc/BRIEF.md
# Late-Write Pipelined Burst SRAM

This block is a synchronous, single-data-rate static memory. It holds a small parameterised array of 36-bit words, and each word is split into four 9-bit bytes. Address, enables and command inputs are sampled on the rising clock edge. Write data follows its command by one edge. Read data leaves through a single output register. A two-bit counter inside the block generates the addresses of a burst. The counter advances in linear order and returns to the loaded address after four beats.

Selection takes three enables. One is fixed active low. The other two each match against a polarity input, so four instances can share two address lines for depth expansion with no external decode. Data and echo-clock outputs are gated separately. A deselect on the fixed enable idles the data bus but keeps the echo clock running. A mismatch on either programmable enable (a bank deselect) silences both. Data leaves on separate `dout` and `dout_oe` ports instead of a bidirectional pin.

Top module: `lw_burst_sram`

## Requirements
- R1: The block is selected only when `ce_n` is 0, `sel2` equals `pol2` and `sel3` equals `pol3`. A command with `adv` = 0 and either programmable enable mismatched is a bank deselect. A command with `adv` = 0, both programmable enables matched and `ce_n` = 1 is a plain deselect.
- R2: With `adv` = 0 and the block selected, `addr` is loaded. `we_n` = 0 starts a write and `we_n` = 1 starts a read.
- R3: For a read whose address is loaded at edge n, the word at that address appears on `dout` after edge n+1, with `dout_oe` = 1.
- R4: For a write beat sampled at edge n, the block stores the value on `din` sampled at edge n+1.
- R5: With `adv` = 1 after a read or write, the low two address bits step 00→01→10→11→00 and the upper bits stay the same. The fourth continue returns to the loaded address.
- R6: `bw_n[i]` (active low, sampled with the write beat) enables byte i, which is bits [9i+8:9i]. Any combination is allowed. With all bits high, the beat stores nothing, but the address still loads or advances.
- R7: After edge n+1, `dout_oe` is 0 when the command sampled at edge n was a deselect, a bank deselect or a write.
- R8: After edge n+1, `cq_oe` is 0 only when the operation at edge n was a bank deselect. A deselect by `ce_n` alone leaves `cq_oe` at 1. `cq` follows `clk` and `cq_n` follows its inverse while `cq_oe` = 1. Both are held at 0 otherwise.
- R9: `adv` = 1 after a deselect or a bank deselect keeps that state, whatever the enables and `we_n` are.
- R10: A read loaded on the edge that captures late-write data for the same address returns the newly written bytes.
- R11: `rst_n` low resets the block asynchronously to the bank-deselect state. `dout_oe` and `cq_oe` are 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, loaded when `adv` = 0 |
| adv | input | 1 | 0 = load a new command, 1 = continue the current one |
| we_n | input | 1 | 0 = write, 1 = read (on load) |
| ce_n | input | 1 | Fixed active-low enable |
| sel2 | input | 1 | Programmable enable 2 |
| sel3 | input | 1 | Programmable enable 3 |
| pol2 | input | 1 | Level at which `sel2` counts as true |
| pol3 | input | 1 | Level at which `sel3` counts as true |
| bw_n | input | NBYTES | Active-low byte write enables |
| din | input | NBYTES*BYTE_W | Late write data |
| dout | output | NBYTES*BYTE_W | Read data from the output register |
| dout_oe | output | 1 | Data output enable |
| cq | output | 1 | Echo clock, in phase |
| cq_n | output | 1 | Echo clock, inverted |
| cq_oe | output | 1 | Echo clock enable |

## Verification
The bench targets these corner cases, and each has a distinct failure signature:
- A burst that starts mid-quad must wrap inside its four-word group. A counter that carries into the upper bits would read and write a neighbouring group.
- A write abort (all byte enables high) must still advance the address. A design that froze the counter would shift every later beat of the burst by one word.
- An `adv` = 1 continue after a deselect must stay deselected. A design that resumed the last access would drive stale data.
- A `ce_n` deselect must leave the echo clock running while a mismatched programmable enable stops it. Mixing up the two rules would show as a wrong `cq_oe` one cycle after the command.
- A read issued right behind a write to the same address must return the new bytes. A design that samples the array one edge too early would return the old bytes.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  // Operation held by the command stage; also the "previous operation" for continues.
  typedef enum logic [1:0] {
    OP_BDSEL = 2'd0,
    OP_DSEL  = 2'd1,
    OP_RD    = 2'd2,
    OP_WR    = 2'd3
  } lw_op_e;

endpackage

// File: rtl/lw_cmd_ctrl.sv
module lw_cmd_ctrl
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              we_n,
  input  logic              ce_n,
  input  logic              sel2,
  input  logic              sel3,
  input  logic              pol2,
  input  logic              pol3,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBYTES-1:0] bw_n,
  output lw_op_e            op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [NBYTES-1:0] mask_q
);

  localparam int HI = ADDR_W - 1;

  lw_op_e            op_d;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;
  logic [NBYTES-1:0] mask_d;
  logic              bank_ok;
  logic              access_q;

  assign bank_ok  = (sel2 == pol2) && (sel3 == pol3);
  assign access_q = (op_q == OP_RD) || (op_q == OP_WR);

  always_comb begin
    op_d    = op_q;
    addr_d  = addr_q;
    addr_en = 1'b0;
    if (!adv) begin
      if (!bank_ok)   op_d = OP_BDSEL;
      else if (ce_n)  op_d = OP_DSEL;
      else if (we_n)  op_d = OP_RD;
      else            op_d = OP_WR;
      if (bank_ok && !ce_n) begin
        addr_d  = addr;
        addr_en = 1'b1;
      end
    end else if (access_q) begin
      addr_d  = {addr_q[HI:2], addr_q[1:0] + 2'd1};
      addr_en = 1'b1;
    end
    mask_d = (op_d == OP_WR) ? ~bw_n : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_BDSEL;
      mask_q <= '0;
    end else begin
      op_q   <= op_d;
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  // R5
  burst_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && access_q |=> (addr_q[1:0] == $past(addr_q[1:0]) + 2'd1)
                        && (addr_q[HI:2] == $past(addr_q[HI:2])));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !access_q |=> $stable(op_q));

  // R1
  bank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv && ((sel2 != pol2) || (sel3 != pol3)) |=> op_q == OP_BDSEL);

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [NBYTES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic [NBYTES*BYTE_W-1:0] wr_data,
  output logic [NBYTES*BYTE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[b]) lane_mem[acc_addr] <= wr_data[b*BYTE_W +: BYTE_W];
    end

    assign rd_data[b*BYTE_W +: BYTE_W] = lane_mem[acc_addr];
  end

endmodule

// File: rtl/lw_out_stage.sv
module lw_out_stage
  import lw_sram_pkg::*;
#(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lw_op_e        op,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          cq,
  output logic          cq_n,
  output logic          cq_oe
);

  logic dout_oe_d;
  logic cq_oe_d;
  logic load_en;

  assign dout_oe_d = (op == OP_RD);
  assign cq_oe_d   = (op != OP_BDSEL);
  assign load_en   = (op == OP_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_oe <= 1'b0;
      cq_oe   <= 1'b0;
    end else begin
      dout_oe <= dout_oe_d;
      cq_oe   <= cq_oe_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) dout <= rd_data;
  end

  assign cq   = cq_oe & clk;
  assign cq_n = cq_oe & ~clk;

  // R8
  echo_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> cq_oe);

endmodule

// File: rtl/lw_burst_sram.sv
module lw_burst_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     adv,
  input  logic                     we_n,
  input  logic                     ce_n,
  input  logic                     sel2,
  input  logic                     sel3,
  input  logic                     pol2,
  input  logic                     pol3,
  input  logic [NBYTES-1:0]        bw_n,
  input  logic [NBYTES*BYTE_W-1:0] din,
  output logic [NBYTES*BYTE_W-1:0] dout,
  output logic                     dout_oe,
  output logic                     cq,
  output logic                     cq_n,
  output logic                     cq_oe
);

  localparam int DW = NBYTES * BYTE_W;

  lw_op_e            op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [NBYTES-1:0] mask_q;
  logic [DW-1:0]     rd_data;

  lw_cmd_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .adv(adv), .we_n(we_n), .ce_n(ce_n),
    .sel2(sel2), .sel3(sel3), .pol2(pol2), .pol3(pol3),
    .addr(addr), .bw_n(bw_n),
    .op_q(op_q), .addr_q(addr_q), .mask_q(mask_q)
  );

  // Late data lands on the edge after the beat; reads sample the array on that same edge.
  lw_sram_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
    .clk(clk), .wr_en(op_q == OP_WR), .wr_mask(mask_q),
    .acc_addr(addr_q), .wr_data(din), .rd_data(rd_data)
  );

  lw_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .op(op_q), .rd_data(rd_data),
    .dout(dout), .dout_oe(dout_oe), .cq(cq), .cq_n(cq_n), .cq_oe(cq_oe)
  );

  logic bank_sel;
  assign bank_sel = (sel2 == pol2) && (sel3 == pol3);

  // R7
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv && !ce_n && !we_n && bank_sel |=> ##1 !dout_oe);

  // R8
  ce_keeps_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv && ce_n && bank_sel |=> ##1 cq_oe);

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !dout_oe && !cq_oe);

endmodule

// File: tb/sim_lw_burst_sram.sv
module sim_lw_burst_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BWD = 9;
  localparam int DW = NB * BWD;
  localparam int DEPTH = 1 << AW;
  localparam int WDOG = 50000;

  logic clk, rst_n, adv, we_n, ce_n, sel2, sel3, pol2, pol3;
  logic [AW-1:0] addr;
  logic [NB-1:0] bw_n;
  logic [DW-1:0] din, dout;
  logic dout_oe, cq, cq_n, cq_oe;

  lw_burst_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BWD)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adv(adv), .we_n(we_n), .ce_n(ce_n),
    .sel2(sel2), .sel3(sel3), .pol2(pol2), .pol3(pol3), .bw_n(bw_n), .din(din),
    .dout(dout), .dout_oe(dout_oe), .cq(cq), .cq_n(cq_n), .cq_oe(cq_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit chk_on = 0, done = 0;
  string cur_req = "R11";

  // reference model: 0 bank-deselect, 1 deselect, 2 read, 3 write
  int m_op = 0, m_addr = 0;
  logic [NB-1:0] m_mask = '0;
  logic [DW-1:0] mmem [DEPTH];
  logic e_oe = 1'b0, e_cq = 1'b0;
  logic [DW-1:0] e_dout = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_op = 0; m_mask = '0; e_oe = 1'b0; e_cq = 1'b0;
    end else begin
      e_oe = (m_op == 2);
      e_cq = (m_op != 0);
      if (m_op == 2) e_dout = mmem[m_addr];
      if (m_op == 3)
        for (int b = 0; b < NB; b++)
          if (m_mask[b]) mmem[m_addr][b*BWD +: BWD] = din[b*BWD +: BWD];
      if (!adv) begin
        if (!((sel2 == pol2) && (sel3 == pol3))) m_op = 0;
        else if (ce_n) m_op = 1;
        else begin
          m_op = we_n ? 2 : 3;
          m_addr = int'(addr);
        end
      end else if (m_op >= 2) begin
        m_addr = (m_addr & ~3) | ((m_addr + 1) & 3);
      end
      m_mask = ~bw_n;
    end
  end

  task automatic fail(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_bad++;
    $display("FAIL %s %s at cycle %0d: actual %h expected %h", cur_req, what, cyc, act, exp);
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      n_vec++;
      if (dout_oe !== e_oe) fail("dout_oe", DW'(dout_oe), DW'(e_oe));
      if (cq_oe !== e_cq) fail("cq_oe", DW'(cq_oe), DW'(e_cq));
      if (cq_n !== e_cq) fail("cq_n", DW'(cq_n), DW'(e_cq));
      if (cq !== 1'b0) fail("cq", DW'(cq), '0);
      if (e_oe && dout !== e_dout) fail("dout", dout, e_dout);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      n_bad++;
      $display("FAIL %s watchdog: actual %0d cycles expected below %0d", cur_req, cyc, WDOG);
      finish_run();
    end
  end

  // one command per cycle, applied on the falling edge; din is fresh random each cycle
  task automatic drive(input logic a, input logic w, input logic c, input logic s2,
                       input logic s3, input logic [NB-1:0] b, input int ad);
    adv = a; we_n = w; ce_n = c; sel2 = s2; sel3 = s3; bw_n = b;
    addr = AW'(ad);
    din = {$urandom, $urandom};
    @(negedge clk);
  endtask

  task automatic wr(input int ad, input logic [NB-1:0] b); drive(0, 0, 0, pol2, pol3, b, ad); endtask
  task automatic rd(input int ad); drive(0, 1, 0, pol2, pol3, '1, ad); endtask
  task automatic cont(input logic [NB-1:0] b); drive(1, $urandom, $urandom, $urandom, $urandom, b, $urandom); endtask
  task automatic nop(); drive(0, 1, 1, pol2, pol3, '1, 0); endtask

  initial begin
    rst_n = 1'b0; pol2 = 1'b1; pol3 = 1'b0;
    adv = 0; we_n = 1; ce_n = 1; sel2 = 0; sel3 = 0; bw_n = '1; addr = '0; din = '0;
    repeat (2) @(negedge clk);
    chk_on = 1;                       // R11: outputs quiet while held in reset
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    nop();

    cur_req = "R2 R4";                // fill the array with four-beat bursts
    for (int base = 0; base < DEPTH; base += 4) begin
      wr(base, '0);
      repeat (3) cont('0);
    end
    nop(); nop();

    cur_req = "R3";
    rd(5); nop(); rd(17); rd(63); rd(0); nop(); nop();

    cur_req = "R5";                   // start mid-quad, four continues wrap to base
    rd(10); repeat (4) cont('1); nop();
    wr(45, '0); repeat (4) cont('0); nop(); rd(44); repeat (3) cont('1); nop();

    cur_req = "R6";
    wr(20, 4'b1110); cont(4'b1101); cont(4'b1111); cont(4'b0000); cont(4'b0110);
    nop(); rd(20); repeat (3) cont('1); nop();
    wr(30, 4'b1111); cont(4'b1111); cont(4'b1011); nop(); rd(28); repeat (3) cont('1); nop();

    cur_req = "R10";
    for (int k = 0; k < 6; k++) begin
      wr(33 + k, 4'b0101 ^ NB'(k)); rd(33 + k);
    end
    nop(); nop();

    cur_req = "R7 R8 R9";
    rd(3); nop(); repeat (3) cont('1);
    rd(4); drive(0, 1, 0, ~pol2, pol3, '1, 4); repeat (3) cont('1);
    rd(6); drive(0, 0, 1, pol2, ~pol3, '0, 6); drive(1, 0, 0, pol2, pol3, '0, 6); nop();
    wr(7, '0); nop(); nop();

    cur_req = "R1";
    for (int p = 0; p < 4; p++) begin
      pol2 = p[1]; pol3 = p[0];
      for (int s = 0; s < 4; s++) begin
        drive(0, 1, 0, s[1], s[0], '1, 8 + s + 4 * p);
        drive(0, 1, 1, s[1], s[0], '1, 0);
      end
      drive(0, 1, 1, pol2, pol3, '1, 0);   // R1: ce_n high with programmable enables true
    end
    nop(); nop();

    cur_req = "R1 R5 R6 R10";
    for (int k = 0; k < 600; k++) begin
      logic lw;
      lw = ($urandom % 3) == 0;
      drive(lw, $urandom, ($urandom % 5) == 0, ($urandom % 6) == 0 ? ~pol2 : pol2,
            ($urandom % 6) == 0 ? ~pol3 : pol3, NB'($urandom), $urandom);
    end
    nop(); nop();

    cur_req = "R11";                  // asynchronous reset in the middle of a read burst
    rd(12); cont('1); cont('1);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    n_vec++;
    if (dout_oe !== 1'b0 || cq_oe !== 1'b0)
      fail("async reset oe", DW'({dout_oe, cq_oe}), '0);
    @(negedge clk);
    adv = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) drive(1, 1, 0, pol2, pol3, '1, 0);  // R11/R9: continue after reset stays idle
    rd(12); nop(); nop();

    finish_run();
  end

endmodule